// File: doc/BRIEF.md
# Bit-Addressable I/O Register Space

This block is the I/O register file of a small 8-bit processor core. It decodes one access port that can name a register in two ways: by its 6-bit I/O index (0x00 to 0x3F), or through the data-memory alias, where the same register sits 0x20 higher (0x20 to 0x5F). On the same port, single-bit set, clear and test commands are accepted for the low half of the I/O space only. A single-bit set or clear rewrites the whole register with one bit changed.

Three registers are implemented. The processor status register sits at I/O 0x3F. It holds the global interrupt enable, which is cleared by interrupt entry and set by interrupt return, and a one-bit store used by bit-transfer operations. A peripheral enable register sits at I/O 0x0D. A peripheral event register with write-one-to-clear flags sits at I/O 0x0E. Instruction decode, the ALU and the real peripherals are outside the block. Strobes and flag-set inputs stand in for them. A single combined interrupt request leaves the block.

Top module: `ioreg_space`

## Requirements
- R1: With `acc_dmem`=0 the address is the I/O index itself. Indices 0x00 to 0x3F select a register location. Addresses 0x40 and up select nothing: a write there changes no register and a read returns 0.
- R2: With `acc_dmem`=1, data addresses 0x20 to 0x5F reach I/O index (address − 0x20). Data addresses below 0x20 or above 0x5F select nothing.
- R3: Command codes on `acc_cmd` are 0 idle, 1 write, 2 bit set, 3 bit clear and 4 bit test. For bit commands the bit index is `acc_wdata[2:0]`. A bit command is legal only when the decoded I/O index is 0x00 to 0x1F. Otherwise `acc_illegal` is 1 in that cycle and the command changes no register.
- R4: A legal bit set or bit clear reads the whole register, changes the chosen bit, and writes all eight bits back on the next rising edge. As a result, every event flag that reads as 1 is cleared, apart from a flag that a bit clear targets.
- R5: The status register is at I/O 0x3F. From bit 7 down to bit 0 it holds I, T, H, S, V, N, Z and C. All eight bits are readable and writable, and all reset to 0.
- R6: `irq_take` clears I and `irq_ret` sets I on the next edge. The priority is: interrupt entry first, then interrupt return, then a software write.
- R7: `irq_out` is 1 exactly when I is 1 and some event flag is 1 with its enable bit set. When I is 0, `irq_out` is 0.
- R8: `t_store` copies `t_byte[t_sel]` into T on the next edge and overrides a same-cycle software write to T. `t_load_byte` equals `t_byte` with bit `t_sel` replaced by the current T.
- R9: The event register at I/O 0x0E holds its flags in bits 3:0. A written 1 clears that flag, and a written 0 leaves it. A `flag_set` bit sets its flag. When a set and a clear hit the same flag in the same cycle, the set wins.
- R10: The enable register at I/O 0x0D holds enables in bits 3:0, one per event flag. Reserved bits 7:4 of both peripheral registers always read as 0. Reads of unimplemented indices return 0, and writes to them are ignored.
- R11: Reads are combinational from the address. For a legal bit test, `bit_test` shows the selected bit of the register. In every other case `bit_test` is 0, and a bit test changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_cmd | input | 3 | Access command code |
| acc_dmem | input | 1 | 1 = data-memory alias addressing, 0 = direct I/O index |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Write data; bits 2:0 are the bit index for bit commands |
| acc_rdata | output | 8 | Combinational read data of the addressed register |
| acc_illegal | output | 1 | Bit command outside the bit-addressable range |
| bit_test | output | 1 | Result of a legal bit test |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_ret | input | 1 | Interrupt return strobe |
| t_store | input | 1 | Bit-store request into T |
| t_sel | input | 3 | Bit position for bit store and bit load |
| t_byte | input | 8 | Source byte for bit store and bit load |
| t_load_byte | output | 8 | `t_byte` with the selected bit replaced by T |
| flag_set | input | 4 | Hardware event flag set pulses |
| irq_out | output | 1 | Combined, globally gated interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- the priority of entry and return on the I bit;
- T capture;
- the per-flag set-wins and write-one-to-clear behaviour;
- gating of the interrupt request by I;
- the rule that an illegal bit command leaves the registers unchanged;
- the rule that unmapped reads return zero.

Only the bench's scenarios show the other behaviours: the two address maps reaching the same storage, the side effect of a whole-register bit rewrite on pending flags, the masking of reserved bits, and the result of a bit test.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_BSET  = 3'd2,
    CMD_BCLR  = 3'd3,
    CMD_BTEST = 3'd4
  } io_cmd_e;

  localparam int DATA_W = 8;
  localparam int BIT_IW = $clog2(DATA_W);

  // status register bit positions
  localparam int SR_I = 7;
  localparam int SR_T = 6;

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
  import ioreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IO_SPAN   = 64,
  parameter int ALIAS_OFS = 32,
  parameter int BIT_SPAN  = 32,
  parameter int CTRL_IDX  = 13,
  parameter int FLAG_IDX  = 14,
  parameter int SREG_IDX  = 63
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dmem,
  input  logic [2:0]        cmd,
  output logic              sel_ctrl,
  output logic              sel_flag,
  output logic              sel_sreg,
  output logic              reg_we,
  output logic              use_rmw,
  output logic              test_ok,
  output logic              illegal
);

  localparam int IO_AW = $clog2(IO_SPAN);
  localparam logic [ADDR_W-1:0] ALIAS_LO = ADDR_W'(ALIAS_OFS);
  localparam logic [ADDR_W-1:0] ALIAS_HI = ADDR_W'(ALIAS_OFS + IO_SPAN - 1);
  localparam logic [ADDR_W-1:0] DIRECT_HI = ADDR_W'(IO_SPAN - 1);
  localparam logic [IO_AW-1:0] BIT_LIMIT = IO_AW'(BIT_SPAN - 1);

  logic [ADDR_W-1:0] rel;
  logic [IO_AW-1:0]  io_idx;
  logic              io_valid;
  logic              is_write, is_setclr, is_test, bit_ok;

  always_comb begin
    if (dmem) begin
      io_valid = (addr >= ALIAS_LO) && (addr <= ALIAS_HI);
      rel      = addr - ALIAS_LO;
    end else begin
      io_valid = (addr <= DIRECT_HI);
      rel      = addr;
    end
    io_idx = IO_AW'(rel);
  end

  always_comb begin
    is_write  = (cmd == CMD_WRITE);
    is_setclr = (cmd == CMD_BSET) || (cmd == CMD_BCLR);
    is_test   = (cmd == CMD_BTEST);
    bit_ok    = io_valid && (io_idx <= BIT_LIMIT);
    illegal   = (is_setclr || is_test) && !bit_ok;
    test_ok   = is_test && bit_ok;
    use_rmw   = is_setclr;
    reg_we    = (is_write && io_valid) || (is_setclr && bit_ok);
    sel_ctrl  = io_valid && (io_idx == IO_AW'(CTRL_IDX));
    sel_flag  = io_valid && (io_idx == IO_AW'(FLAG_IDX));
    sel_sreg  = io_valid && (io_idx == IO_AW'(SREG_IDX));
  end

endmodule

// File: rtl/ioreg_sreg.sv
module ioreg_sreg
  import ioreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_take,
  input  logic              irq_ret,
  input  logic              t_store,
  input  logic [BIT_IW-1:0] t_sel,
  input  logic [DATA_W-1:0] t_byte,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] t_load_byte
);

  logic [DATA_W-1:0] nxt;
  logic              en;

  // next state: write, then return, then entry; bit store owns T
  always_comb begin
    nxt = q;
    if (we)       nxt = wdata;
    if (irq_ret)  nxt[SR_I] = 1'b1;
    if (irq_take) nxt[SR_I] = 1'b0;
    if (t_store)  nxt[SR_T] = t_byte[t_sel];
    en = we || irq_ret || irq_take || t_store;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end

  always_comb begin
    t_load_byte        = t_byte;
    t_load_byte[t_sel] = q[SR_T];
  end

  // R6: entry clears I whatever else happens
  a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !q[SR_I]);
  // R6: return sets I unless entry coincides
  a_r6_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_take) |=> q[SR_I]);
  // R8: bit store captures the selected bit
  a_r8_t_capture: assert property (@(posedge clk) disable iff (!rst_n)
    t_store |=> (q[SR_T] == $past(t_byte[t_sel])));
  // R5: plain software write lands whole
  a_r5_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !irq_ret && !irq_take && !t_store) |=> (q == $past(wdata)));

endmodule

// File: rtl/ioreg_flags.sv
module ioreg_flags #(
  parameter int FLAG_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_N-1:0] wdata,
  input  logic [FLAG_N-1:0] set,
  output logic [FLAG_N-1:0] q
);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic nxt;
    logic en;

    always_comb begin
      en  = set[i] || (we && wdata[i]);
      nxt = set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= nxt;
    end

    // R9: a hardware event is never lost
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    // R9: a written one clears
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[i] && !set[i]) |=> !q[i]);
    // R9: otherwise the flag holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !(we && wdata[i])) |=> (q[i] == $past(q[i])));
  end

endmodule

// File: rtl/ioreg_space.sv
module ioreg_space
  import ioreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IO_SPAN   = 64,
  parameter int ALIAS_OFS = 32,
  parameter int BIT_SPAN  = 32,
  parameter int FLAG_N    = 4,
  parameter int CTRL_IDX  = 13,
  parameter int FLAG_IDX  = 14,
  parameter int SREG_IDX  = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        acc_cmd,
  input  logic              acc_dmem,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_illegal,
  output logic              bit_test,
  input  logic              irq_take,
  input  logic              irq_ret,
  input  logic              t_store,
  input  logic [BIT_IW-1:0] t_sel,
  input  logic [DATA_W-1:0] t_byte,
  output logic [DATA_W-1:0] t_load_byte,
  input  logic [FLAG_N-1:0] flag_set,
  output logic              irq_out
);

  localparam int PAD_W = DATA_W - FLAG_N;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic sel_ctrl, sel_flag, sel_sreg, reg_we, use_rmw, test_ok;

  ioreg_decode #(
    .ADDR_W(ADDR_W), .IO_SPAN(IO_SPAN), .ALIAS_OFS(ALIAS_OFS),
    .BIT_SPAN(BIT_SPAN), .CTRL_IDX(CTRL_IDX), .FLAG_IDX(FLAG_IDX),
    .SREG_IDX(SREG_IDX)
  ) u_dec (
    .addr(acc_addr), .dmem(acc_dmem), .cmd(acc_cmd),
    .sel_ctrl(sel_ctrl), .sel_flag(sel_flag), .sel_sreg(sel_sreg),
    .reg_we(reg_we), .use_rmw(use_rmw), .test_ok(test_ok),
    .illegal(acc_illegal)
  );

  logic [FLAG_N-1:0] ctrl_q, ctrl_nxt, flag_q;
  logic              ctrl_en;
  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] rd_val, rmw_val, wr_val;
  logic [BIT_IW-1:0] bit_idx;

  // combinational read mux, reserved bits zero
  always_comb begin
    rd_val = '0;
    if (sel_ctrl)      rd_val = {{PAD_W{1'b0}}, ctrl_q};
    else if (sel_flag) rd_val = {{PAD_W{1'b0}}, flag_q};
    else if (sel_sreg) rd_val = sreg_q;
  end
  assign acc_rdata = rd_val;

  // whole-register rewrite for bit set / clear
  always_comb begin
    bit_idx          = acc_wdata[BIT_IW-1:0];
    rmw_val          = rd_val;
    rmw_val[bit_idx] = (acc_cmd == CMD_BSET);
    wr_val           = use_rmw ? rmw_val : acc_wdata;
    bit_test         = test_ok && rd_val[bit_idx];
  end

  // enable register
  always_comb begin
    ctrl_en  = reg_we && sel_ctrl;
    ctrl_nxt = wr_val[FLAG_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   ctrl_q <= '0;
    else if (ctrl_en)  ctrl_q <= ctrl_nxt;
  end

  ioreg_flags #(.FLAG_N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .we(reg_we && sel_flag), .wdata(wr_val[FLAG_N-1:0]),
    .set(flag_set), .q(flag_q)
  );

  ioreg_sreg u_sreg (
    .clk(clk), .rst_n(rst_sync_n),
    .we(reg_we && sel_sreg), .wdata(wr_val),
    .irq_take(irq_take), .irq_ret(irq_ret),
    .t_store(t_store), .t_sel(t_sel), .t_byte(t_byte),
    .q(sreg_q), .t_load_byte(t_load_byte)
  );

  assign irq_out = sreg_q[SR_I] && |(flag_q & ctrl_q);

  // R7: no request leaves while I is clear
  a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sreg_q[SR_I] |-> !irq_out);
  // R3: an illegal bit command touches nothing
  a_r3_illegal_noop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_illegal && !irq_take && !irq_ret && !t_store && (flag_set == '0))
      |=> (ctrl_q == $past(ctrl_q)) && (sreg_q == $past(sreg_q))
          && (flag_q == $past(flag_q)));
  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sel_ctrl || sel_flag || sel_sreg) |-> (acc_rdata == '0));
  // R11: a failed bit test never reports one
  a_r11_test_illegal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_illegal |-> !bit_test);

endmodule

// File: tb/sim_ioreg_space.sv
module sim_ioreg_space;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] acc_cmd = 3'd0;
  logic       acc_dmem = 1'b0;
  logic [7:0] acc_addr = 8'h00;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       acc_illegal, bit_test;
  logic       irq_take = 1'b0, irq_ret = 1'b0, t_store = 1'b0;
  logic [2:0] t_sel = 3'd0;
  logic [7:0] t_byte = 8'h00;
  logic [7:0] t_load_byte;
  logic [3:0] flag_set = 4'h0;
  logic       irq_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  ioreg_space u0 (
    .clk(clk), .rst_n(rst_n), .acc_cmd(acc_cmd), .acc_dmem(acc_dmem),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_illegal(acc_illegal), .bit_test(bit_test), .irq_take(irq_take),
    .irq_ret(irq_ret), .t_store(t_store), .t_sel(t_sel), .t_byte(t_byte),
    .t_load_byte(t_load_byte), .flag_set(flag_set), .irq_out(irq_out)
  );

  localparam logic [2:0] NONE = 3'd0, WR = 3'd1, BS = 3'd2, BC = 3'd3, BT = 3'd4;

  typedef struct packed {
    logic [2:0] cmd;
    logic       dmem;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic       ill;
    logic [7:0] raddr;
    logic [7:0] rexp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{WR, 1'b0, 8'h0D, 8'hFF, 1'b0, 8'h0D, 8'h0F},  // R10 reserved bits
    '{WR, 1'b1, 8'h2D, 8'h05, 1'b0, 8'h0D, 8'h05},  // R2 alias
    '{WR, 1'b0, 8'h3F, 8'hA5, 1'b0, 8'h3F, 8'hA5},  // R5 status rw
    '{WR, 1'b1, 8'h5F, 8'h3C, 1'b0, 8'h3F, 8'h3C},  // R2 alias top
    '{WR, 1'b0, 8'h40, 8'hFF, 1'b0, 8'h0D, 8'h05},  // R1 past direct range
    '{WR, 1'b1, 8'h1D, 8'hFF, 1'b0, 8'h0D, 8'h05},  // R2 below alias
    '{WR, 1'b1, 8'h60, 8'hFF, 1'b0, 8'h3F, 8'h3C},  // R2 above alias
    '{BS, 1'b0, 8'h0D, 8'h01, 1'b0, 8'h0D, 8'h07},  // R4 bit set
    '{BC, 1'b1, 8'h2D, 8'h00, 1'b0, 8'h0D, 8'h06},  // R4 bit clear via alias
    '{BS, 1'b0, 8'h3F, 8'h07, 1'b1, 8'h3F, 8'h3C},  // R3 above bit range
    '{BC, 1'b0, 8'h80, 8'h01, 1'b1, 8'h0D, 8'h06},  // R3 unmapped
    '{BS, 1'b0, 8'h0D, 8'h06, 1'b0, 8'h0D, 8'h06}   // R10 reserved bit set
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    acc_cmd = NONE; acc_dmem = 1'b0; irq_take = 1'b0; irq_ret = 1'b0;
    t_store = 1'b0; flag_set = 4'h0;
  endtask

  task automatic op(input logic [2:0] c, input logic d, input logic [7:0] a,
                    input logic [7:0] w);
    @(negedge clk);
    clear_strobes();
    acc_cmd = c; acc_dmem = d; acc_addr = a; acc_wdata = w;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    clear_strobes();
    acc_addr = a;
    #1;
    chk(req, acc_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state: R5, R10, R7
    rd("R5 reset status", 8'h3F, 8'h00);
    rd("R10 reset enables", 8'h0D, 8'h00);
    rd("R10 reset flags", 8'h0E, 8'h00);
    chk("R7 reset irq", {7'd0, irq_out}, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      op(VEC[i].cmd, VEC[i].dmem, VEC[i].addr, VEC[i].wdata);
      #1;
      chk($sformatf("R3 illegal flag vec %0d", i), {7'd0, acc_illegal}, {7'd0, VEC[i].ill});
      rd($sformatf("R1 R2 R4 table vec %0d", i), VEC[i].raddr, VEC[i].rexp);
    end

    // unimplemented location: R10, R1
    op(WR, 1'b0, 8'h05, 8'hFF);
    rd("R10 unimplemented read", 8'h05, 8'h00);
    rd("R1 out-of-range read", 8'h80, 8'h00);

    // write-one-to-clear: R9
    op(NONE, 1'b0, 8'h00, 8'h00); flag_set = 4'hA;
    rd("R9 flags set", 8'h0E, 8'h0A);
    op(WR, 1'b0, 8'h0E, 8'h02);
    rd("R9 one clears", 8'h0E, 8'h08);
    op(WR, 1'b0, 8'h0E, 8'h00);
    rd("R9 zero keeps", 8'h0E, 8'h08);
    op(WR, 1'b1, 8'h2E, 8'h08); flag_set = 4'h8;
    rd("R9 set wins", 8'h0E, 8'h08);
    op(WR, 1'b0, 8'h0E, 8'h08);
    rd("R9 clear last", 8'h0E, 8'h00);

    // bit rewrite side effect: R4
    op(NONE, 1'b0, 8'h00, 8'h00); flag_set = 4'hA;
    rd("R4 flags armed", 8'h0E, 8'h0A);
    op(BC, 1'b0, 8'h0E, 8'h01);
    rd("R4 clear keeps target, drops others", 8'h0E, 8'h02);
    op(NONE, 1'b0, 8'h00, 8'h00); flag_set = 4'h8;
    rd("R4 flags rearmed", 8'h0E, 8'h0A);
    op(BS, 1'b0, 8'h0E, 8'h02);
    rd("R4 set drops all", 8'h0E, 8'h00);

    // interrupt enable: R6, R7 (enables 0x06, status 0x3C)
    op(NONE, 1'b0, 8'h00, 8'h00); flag_set = 4'h2;
    rd("R7 flag pending", 8'h0E, 8'h02);
    chk("R7 gated by I", {7'd0, irq_out}, 8'h00);
    op(NONE, 1'b0, 8'h00, 8'h00); irq_ret = 1'b1;
    rd("R6 return sets I", 8'h3F, 8'hBC);
    chk("R7 request passes", {7'd0, irq_out}, 8'h01);
    op(NONE, 1'b0, 8'h00, 8'h00); irq_take = 1'b1;
    rd("R6 entry clears I", 8'h3F, 8'h3C);
    chk("R7 request dropped", {7'd0, irq_out}, 8'h00);
    op(WR, 1'b0, 8'h3F, 8'h80); irq_take = 1'b1;
    rd("R6 entry beats write", 8'h3F, 8'h00);
    op(WR, 1'b0, 8'h3F, 8'h00); irq_ret = 1'b1;
    rd("R6 return beats write", 8'h3F, 8'h80);
    op(NONE, 1'b0, 8'h00, 8'h00); irq_take = 1'b1; irq_ret = 1'b1;
    rd("R6 entry beats return", 8'h3F, 8'h00);
    op(NONE, 1'b0, 8'h00, 8'h00); irq_ret = 1'b1;
    rd("R6 return again", 8'h3F, 8'h80);

    // bit store / load: R8
    op(NONE, 1'b0, 8'h00, 8'h00); t_store = 1'b1; t_sel = 3'd4; t_byte = 8'h10;
    rd("R8 store one", 8'h3F, 8'hC0);
    t_sel = 3'd2; t_byte = 8'h00; #1;
    chk("R8 load one", t_load_byte, 8'h04);
    op(WR, 1'b0, 8'h3F, 8'h40); t_store = 1'b1; t_sel = 3'd4; t_byte = 8'hEF;
    rd("R8 store beats write", 8'h3F, 8'h00);
    t_sel = 3'd0; t_byte = 8'hFF; #1;
    chk("R8 load zero", t_load_byte, 8'hFE);

    // bit test: R11 (enables 0x06, flags 0x02)
    op(BT, 1'b0, 8'h0D, 8'h02); #1;
    chk("R11 test one", {7'd0, bit_test}, 8'h01);
    op(BT, 1'b0, 8'h0D, 8'h00); #1;
    chk("R11 test zero", {7'd0, bit_test}, 8'h00);
    op(BT, 1'b1, 8'h2E, 8'h01); #1;
    chk("R11 test via alias", {7'd0, bit_test}, 8'h01);
    op(BT, 1'b0, 8'h3F, 8'h07); #1;
    chk("R3 test illegal", {7'd0, acc_illegal}, 8'h01);
    chk("R11 illegal test zero", {7'd0, bit_test}, 8'h00);
    rd("R11 test no effect", 8'h0E, 8'h02);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule